// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Front End

This block is the serial front end of a 256-word by 16-bit serial EEPROM. It runs on an internal system clock. It synchronizes the chip-select, serial-clock and serial-data-in pins, and it finds rising serial-clock edges. It waits for a start bit, then shifts in a two-bit opcode, an 8-bit address and, for the two data-carrying instructions, a 16-bit data word. It decodes seven instructions and keeps an erase/write enable latch.

For a read, it fetches words from the memory array through a registered read port. It drives a leading zero and then the word, most significant bit first. If the host keeps clocking, it continues with the following words.

Erase and write instructions go to a separate program-cycle engine as one-cycle request pulses. The front end reports the busy/ready state of that engine on the data-out pin when the host polls it. The memory read port follows a fixed-latency rule rather than valid/ready: the word must be present on `mem_rd_data_i` in the cycle after `mem_rd_en_o` is high. The request port has no back-pressure. A request that arrives while `prog_busy_i` is high is dropped, not held.

Top module: `mw_cmd_front`

## Requirements
- R1: While chip select is high and no start bit has been seen, serial-clock edges with data-in low change nothing and leave the data-out enable low. The first rising serial-clock edge that has both chip select and data-in high is the start bit.
- R2: After the start bit, the next two bits are the opcode: 10 read, 01 write, 11 erase. Opcode 00 is extended by the two top address bits: 11 enable, 00 disable, 10 erase-all, 01 write-all. The remaining address bits of the extended codes are ignored.
- R3: The address is 8 bits, MSB first. An instruction without data is complete after 11 serial-clock rises, start bit included. Write and write-all need 27 rises, with 16 data bits sent MSB first. No request leaves before the last required bit.
- R4: Input bits are taken on rising serial-clock edges. Read data advances one bit per rising edge.
- R5: The data-out enable is low after reset and at every other time, except while a read or a status poll is being presented. It goes low within a few system cycles of chip select falling.
- R6: A read drives one 0 bit as soon as the last address bit has been taken. The next rising edges present the addressed word, MSB first.
- R7: Chip select low returns the control logic to the waiting state. After an instruction completes, further edges with chip select high, including new start bits, are ignored until chip select has been low.
- R8: The enable latch is cleared by reset and by the disable instruction, and it is set by the enable instruction. Erase, write, erase-all and write-all produce no request while it is clear.
- R9: An instruction cut short by chip select falling before its last bit produces no request.
- R10: A read clocked past the last bit of a word continues with the next address, with no further 0 bit. Address 255 wraps to 0.
- R11: A request is a one-cycle pulse on `prog_req_o`, with `prog_kind_o` coded erase=0, write=1, erase-all=2, write-all=3, plus the address and the data. A request that would issue while `prog_busy_i` is high is dropped.
- R12: After a request has been accepted, raising chip select again before a start bit enables data-out and shows `prog_busy_i` inverted (0 busy, 1 ready). The next start bit ends this status display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select pin, asynchronous |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| sdi_i | input | 1 | Serial data-in pin, asynchronous |
| sdo_o | output | 1 | Serial data-out value |
| sdo_oe_o | output | 1 | Data-out enable; low means high impedance |
| mem_rd_en_o | output | 1 | Array read strobe |
| mem_rd_addr_o | output | 8 | Array read address |
| mem_rd_data_i | input | 16 | Array word, valid the cycle after the strobe |
| prog_req_o | output | 1 | One-cycle program request pulse |
| prog_kind_o | output | 2 | Request type code |
| prog_addr_o | output | 8 | Request address |
| prog_data_o | output | 16 | Request data word |
| prog_busy_i | input | 1 | Program engine busy |

## Verification
The bench builds the block with its default parameters: 8-bit address, 16-bit word and a two-stage synchronizer. With these values the 11-rise and 27-rise frame lengths and the wrap from address 255 to 0 are reachable in a short run. The serial clock runs at one sixteenth of the system clock, so each serial bit covers several synchronizer delays. This lets the bench sample data-out between serial edges and count exactly when requests leave.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DATA, ST_READ, ST_DONE
  } fe_state_t;

  typedef enum logic [2:0] {
    CM_READ, CM_WRITE, CM_ERASE, CM_EWEN, CM_EWDS, CM_ERAL, CM_WRAL
  } cmd_t;

  localparam logic [1:0] PK_ERASE = 2'd0;
  localparam logic [1:0] PK_WRITE = 2'd1;
  localparam logic [1:0] PK_ERAL  = 2'd2;
  localparam logic [1:0] PK_WRAL  = 2'd3;
endpackage

// File: rtl/mw_sync_edge.sv
`timescale 1ns/1ps
module mw_sync_edge #(
  parameter int STAGES = 2,
  parameter int N      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sync_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mw_cmd_decode.sv
`timescale 1ns/1ps
module mw_cmd_decode
  import mw_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic [1:0] ext_i,
  output cmd_t       cmd_o,
  output logic       has_data_o
);
  always_comb begin
    has_data_o = 1'b0;
    cmd_o      = CM_EWDS;
    unique case (op_i)
      2'b10: cmd_o = CM_READ;
      2'b01: begin cmd_o = CM_WRITE; has_data_o = 1'b1; end
      2'b11: cmd_o = CM_ERASE;
      default: begin
        unique case (ext_i)
          2'b11:   cmd_o = CM_EWEN;
          2'b00:   cmd_o = CM_EWDS;
          2'b10:   cmd_o = CM_ERAL;
          default: begin cmd_o = CM_WRAL; has_data_o = 1'b1; end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/mw_rd_stream.sv
`timescale 1ns/1ps
module mw_rd_stream #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          step_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          bit_o
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [IW-1:0] LAST = IW'(DW - 1);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] sh_q;
  logic [IW-1:0] idx_q;
  logic          ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      ld_q    <= 1'b0;
      rd_en_o <= 1'b0;
      bit_o   <= 1'b0;
    end else if (clr_i) begin
      idx_q   <= '0;
      ld_q    <= 1'b0;
      rd_en_o <= 1'b0;
      bit_o   <= 1'b0;
    end else begin
      rd_en_o <= 1'b0;
      ld_q    <= rd_en_o;
      if (start_i) begin
        addr_q  <= start_addr_i;
        rd_en_o <= 1'b1;
        idx_q   <= '0;
        bit_o   <= 1'b0;
      end else if (step_i) begin
        bit_o <= sh_q[DW-1];
        sh_q  <= {sh_q[DW-2:0], 1'b0};
        if (idx_q == LAST) begin
          idx_q   <= '0;
          addr_q  <= addr_q + 1'b1;
          rd_en_o <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
      if (ld_q) sh_q <= rd_data_i;
    end
  end

  assign rd_addr_o = addr_q;
endmodule

// File: rtl/mw_cmd_front.sv
`timescale 1ns/1ps
module mw_cmd_front
  import mw_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          sck_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic          mem_rd_en_o,
  output logic [AW-1:0] mem_rd_addr_o,
  input  logic [DW-1:0] mem_rd_data_i,
  output logic          prog_req_o,
  output logic [1:0]    prog_kind_o,
  output logic [AW-1:0] prog_addr_o,
  output logic [DW-1:0] prog_data_o,
  input  logic          prog_busy_i
);
  localparam int HW      = 2 + AW;
  localparam int CNT_MAX = (HW > DW) ? HW : DW;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [2:0] pins_s;
  logic       cs_s, sck_s, sdi_s, sck_q, sck_rise;

  mw_sync_edge #(.STAGES(SYNC), .N(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw_i({cs_i, sck_i, sdi_i}), .sync_o(pins_s)
  );
  assign {cs_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_q & cs_s;

  fe_state_t     state_q;
  cmd_t          cmd_q, cmd_w;
  logic          has_data_w;
  logic [CW-1:0] cnt_q;
  logic [HW-2:0] hdr_q;
  logic [HW-1:0] hdr_next;
  logic [DW-2:0] dat_q;
  logic [DW-1:0] dat_next;
  logic [AW-1:0] addr_q;
  logic          wen_q, stat_q, stat_bit_q, rd_mode_q, oe_q;
  logic          last_hdr, last_dat, rd_start, rd_bit, can_issue;

  assign hdr_next  = {hdr_q, sdi_s};
  assign dat_next  = {dat_q, sdi_s};
  assign last_hdr  = (cnt_q == CW'(HW - 1));
  assign last_dat  = (cnt_q == CW'(DW - 1));
  assign can_issue = wen_q & ~prog_busy_i;

  mw_cmd_decode u_dec (
    .op_i(hdr_next[HW-1:HW-2]), .ext_i(hdr_next[AW-1:AW-2]),
    .cmd_o(cmd_w), .has_data_o(has_data_w)
  );

  assign rd_start = cs_s && (state_q == ST_HDR) && sck_rise && last_hdr
                    && (cmd_w == CM_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cmd_q       <= CM_EWDS;
      cnt_q       <= '0;
      hdr_q       <= '0;
      dat_q       <= '0;
      addr_q      <= '0;
      wen_q       <= 1'b0;
      stat_q      <= 1'b0;
      prog_req_o  <= 1'b0;
      prog_kind_o <= PK_ERASE;
      prog_addr_o <= '0;
      prog_data_o <= '0;
    end else begin
      prog_req_o <= 1'b0;
      if (!cs_s) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (sck_rise && sdi_s) begin
            state_q <= ST_HDR;
            cnt_q   <= '0;
            stat_q  <= 1'b0;
          end
          ST_HDR: if (sck_rise) begin
            hdr_q <= hdr_next[HW-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (last_hdr) begin
              cnt_q  <= '0;
              cmd_q  <= cmd_w;
              addr_q <= hdr_next[AW-1:0];
              if (has_data_w)             state_q <= ST_DATA;
              else if (cmd_w == CM_READ)  state_q <= ST_READ;
              else                        state_q <= ST_DONE;
              if (cmd_w == CM_EWEN) wen_q <= 1'b1;
              if (cmd_w == CM_EWDS) wen_q <= 1'b0;
              if ((cmd_w == CM_ERASE || cmd_w == CM_ERAL) && can_issue) begin
                prog_req_o  <= 1'b1;
                prog_kind_o <= (cmd_w == CM_ERASE) ? PK_ERASE : PK_ERAL;
                prog_addr_o <= (cmd_w == CM_ERASE) ? hdr_next[AW-1:0] : '0;
                prog_data_o <= '1;
                stat_q      <= 1'b1;
              end
            end
          end
          ST_DATA: if (sck_rise) begin
            dat_q <= dat_next[DW-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (last_dat) begin
              cnt_q   <= '0;
              state_q <= ST_DONE;
              if (can_issue) begin
                prog_req_o  <= 1'b1;
                prog_kind_o <= (cmd_q == CM_WRITE) ? PK_WRITE : PK_WRAL;
                prog_addr_o <= (cmd_q == CM_WRITE) ? addr_q : '0;
                prog_data_o <= dat_next;
                stat_q      <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  mw_rd_stream #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr_i(~cs_s),
    .start_i(rd_start), .start_addr_i(hdr_next[AW-1:0]),
    .step_i(sck_rise && (state_q == ST_READ)),
    .rd_en_o(mem_rd_en_o), .rd_addr_o(mem_rd_addr_o),
    .rd_data_i(mem_rd_data_i), .bit_o(rd_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q       <= 1'b0;
      rd_mode_q  <= 1'b0;
      stat_bit_q <= 1'b0;
    end else begin
      stat_bit_q <= ~prog_busy_i;
      rd_mode_q  <= cs_s && (rd_start || state_q == ST_READ);
      oe_q       <= cs_s && (rd_start || state_q == ST_READ ||
                    (state_q == ST_IDLE && stat_q && !(sck_rise && sdi_s)));
    end
  end

  assign sdo_oe_o = oe_q;
  assign sdo_o    = rd_mode_q ? rd_bit : stat_bit_q;
endmodule

// File: rtl/mw_cmd_front_chk.sv
`timescale 1ns/1ps
module mw_cmd_front_chk
  import mw_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_s,
  input fe_state_t state_q,
  input logic      wen_q,
  input logic      prog_req_o,
  input logic      prog_busy_i,
  input logic      sdo_o,
  input logic      sdo_oe_o
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req_o |=> !prog_req_o); // R11
  AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req_o |-> !$past(prog_busy_i)); // R11
  AST_REQ_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req_o |-> $past(wen_q)); // R8
  AST_HIZ_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_s) |=> !sdo_oe_o); // R5
  AST_IDLE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> state_q == ST_IDLE); // R7
  AST_READ_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && $past(state_q) == ST_HDR) |-> (sdo_oe_o && !sdo_o)); // R6
endmodule

bind mw_cmd_front mw_cmd_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .state_q(state_q), .wen_q(wen_q),
  .prog_req_o(prog_req_o), .prog_busy_i(prog_busy_i),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
);

// File: tb/mw_cmd_front_tb.sv
`timescale 1ns/1ps
module mw_cmd_front_tb;
  localparam int SH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, busy = 1'b0;
  logic sdo, sdo_oe, rd_en, preq;
  logic [7:0] rd_addr, paddr;
  logic [15:0] rd_data = '0, pdata;
  logic [1:0] pkind;

  int n_chk = 0, n_bad = 0, req_cnt = 0;
  logic [1:0]  rq_kind;
  logic [7:0]  rq_addr;
  logic [15:0] rq_data;

  always #10 clk = ~clk;

  mw_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mem_rd_en_o(rd_en),
    .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
    .prog_req_o(preq), .prog_kind_o(pkind), .prog_addr_o(paddr),
    .prog_data_o(pdata), .prog_busy_i(busy)
  );

  function automatic logic [15:0] word_at(input logic [7:0] a);
    return {a, ~a} ^ 16'h5A3C;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= word_at(rd_addr);

  always @(posedge clk) if (preq === 1'b1) begin
    req_cnt++;
    rq_kind = pkind; rq_addr = paddr; rq_data = pdata;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    sdi = b; tick(SH);
    sck = 1'b1; tick(SH);
    sck = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic select();   cs = 1'b1; tick(6); endtask
  task automatic deselect(); cs = 1'b0; sdi = 1'b0; tick(8); endtask

  task automatic read_word(output logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      bit_out(1'b0);
      w[i] = sdo;
    end
  endtask

  task automatic cmd11(input logic [1:0] op, input logic [7:0] a);
    select(); send({21'd0, 1'b1, op, a}, 11); deselect();
  endtask

  task automatic t_reset();
    chk("R5 reset oe", 32'(sdo_oe), 0);
    chk("R11 reset req", 32'(preq), 0);
  endtask

  task automatic t_read_preamble();
    logic [15:0] w;
    select();
    send(32'h0, 5);
    chk("R1 preamble oe", 32'(sdo_oe), 0);
    send({21'd0, 1'b1, 2'b10, 8'h12}, 11);
    chk("R6 dummy oe", 32'(sdo_oe), 1);
    chk("R6 dummy zero", 32'(sdo), 0);
    read_word(w);
    chk("R4 R2 read word", 32'(w), 32'(word_at(8'h12)));
    deselect();
    chk("R5 oe after cs low", 32'(sdo_oe), 0);
  endtask

  task automatic t_write_locked();
    int c0 = req_cnt;
    select(); send({5'd0, 1'b1, 2'b01, 8'h03, 16'hAAAA}, 27); deselect();
    chk("R8 write while disabled", 32'(req_cnt), 32'(c0));
  endtask

  task automatic t_ewen_write();
    int c0;
    cmd11(2'b00, 8'hC0);
    c0 = req_cnt;
    select();
    send({5'd0, 1'b1, 2'b01, 8'h34, 16'hBEEF} >> 1, 26);
    chk("R3 no request before last bit", 32'(req_cnt), 32'(c0));
    bit_out(1'b1);
    chk("R3 request after 27th", 32'(req_cnt), 32'(c0 + 1));
    chk("R11 write kind", 32'(rq_kind), 1);
    chk("R11 write addr", 32'(rq_addr), 32'h34);
    chk("R11 write data", 32'(rq_data), 32'hBEEF);
    deselect();
  endtask

  task automatic t_erase_family();
    int c0 = req_cnt;
    cmd11(2'b11, 8'h77);
    chk("R2 erase count", 32'(req_cnt), 32'(c0 + 1));
    chk("R2 erase kind", 32'(rq_kind), 0);
    chk("R2 erase addr", 32'(rq_addr), 32'h77);
    cmd11(2'b00, 8'hA5);
    chk("R2 erase-all kind", 32'(rq_kind), 2);
    select(); send({5'd0, 1'b1, 2'b00, 8'h4F, 16'h1234}, 27); deselect();
    chk("R2 write-all count", 32'(req_cnt), 32'(c0 + 3));
    chk("R2 write-all kind", 32'(rq_kind), 3);
    chk("R2 write-all data", 32'(rq_data), 32'h1234);
  endtask

  task automatic t_abort();
    int c0 = req_cnt;
    select(); send({5'd0, 1'b1, 2'b01, 8'h20, 16'h5555} >> 9, 18); deselect();
    chk("R9 truncated write", 32'(req_cnt), 32'(c0));
    select(); send({21'd0, 1'b1, 2'b11, 8'h21} >> 2, 9); deselect();
    chk("R9 truncated erase", 32'(req_cnt), 32'(c0));
  endtask

  task automatic t_after_done();
    int c0 = req_cnt;
    select();
    send({21'd0, 1'b1, 2'b11, 8'h10}, 11);
    send({21'd0, 1'b1, 2'b11, 8'h20}, 11);
    chk("R7 second frame ignored", 32'(req_cnt), 32'(c0 + 1));
    chk("R7 kept first addr", 32'(rq_addr), 32'h10);
    deselect();
  endtask

  task automatic t_status();
    int c0;
    busy = 1'b1;
    select();
    chk("R12 status oe", 32'(sdo_oe), 1);
    chk("R12 status busy", 32'(sdo), 0);
    busy = 1'b0; tick(4);
    chk("R12 status ready", 32'(sdo), 1);
    bit_out(1'b1);
    chk("R12 start ends status", 32'(sdo_oe), 0);
    deselect();
    busy = 1'b1;
    c0 = req_cnt;
    cmd11(2'b11, 8'h05);
    chk("R11 refused while busy", 32'(req_cnt), 32'(c0));
    busy = 1'b0;
  endtask

  task automatic t_seq_read();
    logic [15:0] w;
    select();
    send({21'd0, 1'b1, 2'b10, 8'hFF}, 11);
    chk("R6 dummy at top", 32'(sdo), 0);
    read_word(w);
    chk("R10 word 255", 32'(w), 32'(word_at(8'hFF)));
    read_word(w);
    chk("R10 wrapped word 0", 32'(w), 32'(word_at(8'h00)));
    deselect();
  endtask

  task automatic t_ewds();
    int c0;
    cmd11(2'b00, 8'h3F);
    c0 = req_cnt;
    cmd11(2'b11, 8'h11);
    chk("R8 erase after disable", 32'(req_cnt), 32'(c0));
  endtask

  task automatic t_cs_midread();
    logic [15:0] w;
    select();
    send({21'd0, 1'b1, 2'b10, 8'h40}, 11);
    send(32'h0, 5);
    deselect();
    chk("R5 oe off mid read", 32'(sdo_oe), 0);
    select();
    send({21'd0, 1'b1, 2'b10, 8'h41}, 11);
    read_word(w);
    chk("R7 fresh read after cs low", 32'(w), 32'(word_at(8'h41)));
    deselect();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    tick(5);
    t_reset();
    rst_n = 1'b1;
    tick(4);
    t_read_preamble();
    t_write_locked();
    t_ewen_write();
    t_erase_family();
    t_abort();
    t_after_done();
    t_status();
    t_seq_read();
    t_ewds();
    t_cs_midread();
    summary();
    $finish;
  end
endmodule